// File: doc/BRIEF.md
# Load Element Width and Saturation Formatter

This block sits at the back end of a vector load path. It takes the raw bytes returned by memory for one element access and turns them into a value ready to be written into one element slot of a packed 64-bit register. The access size is 8, 16, 32 or 64 bits. The block first applies the endianness rule, then fits the value to the destination element width, and finally positions the result in the byte lanes that element index `j` occupies.

The byte order is reversed within the access size when the byte-reverse opcode flag and the little-endian mode flag are equal. After that, the value is adapted to the destination width in one of two ways:
- **Plain mode:** the value is zero-extended or truncated.
- **Saturating mode:** the value is treated as signed or unsigned, then widened or clamped.

A destination narrower than the access is an undefined combination. The block reports it on a flag, but still produces a deterministic result. Every result is registered and appears one clock after the request.

Top module: `ld_elem_formatter`

## Requirements
- R1: A request accepted with `in_valid` high at a rising edge appears on the outputs after that edge, with `out_valid` high for exactly one cycle. A synchronous active-high reset clears `out_valid`, `out_data`, `out_mask` and `out_undef` to zero.
- R2: The width codes are 0 = 8 bits, 1 = 16 bits, 2 = 32 bits and 3 = 64 bits. Only the low access-width bytes of `raw_data` are used. They are byte-reversed within the access width exactly when `brev_op` equals `cpu_le`.
- R3: With `sat_en` low and a destination at least as wide as the access, the element is the access-width value zero-extended to the destination width.
- R4: With `sat_en` high and a destination at least as wide as the access, the value is handled as follows:
  - `sat_signed` = 1: the value is sign-extended from its top access bit.
  - `sat_signed` = 0: the value is zero-extended.
- R5: With `sat_en` high and a destination narrower than the access, the value is clamped to the destination range:
  - Signed: the value is read as a two's-complement number. Values above the destination maximum become the maximum (0x7F, 0x7FFF and so on). Values below the destination minimum become the minimum (0x80, 0x8000 and so on). Values in range pass unchanged.
  - Unsigned: values above the destination all-ones value become all ones.
- R6: The element occupies bytes `lane*D` to `lane*D+D-1` of `out_data`, where D is the destination width in bytes and the lanes are in little-endian order. `lane` is `elem_idx` modulo 8/D, so index bits above that range are ignored. `out_mask` has a one for exactly those bytes. All other bytes of `out_data` are zero.
- R7: `out_undef` is high exactly when the destination width code is below the access width code. In that case, with `sat_en` low, the element is the low destination-width bits of the byte-ordered value.
- R8: When `in_valid` is low at a rising edge, `out_valid` is low after it, and `out_data`, `out_mask` and `out_undef` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request qualifier |
| raw_data | input | 64 | Memory read data, access value in the low bytes |
| op_width | input | 2 | Access width code |
| dst_width | input | 2 | Destination element width code |
| brev_op | input | 1 | Byte-reverse opcode flag |
| cpu_le | input | 1 | Processor little-endian mode flag |
| sat_en | input | 1 | Saturating conversion enable |
| sat_signed | input | 1 | 1 = signed saturation, 0 = unsigned |
| elem_idx | input | 3 | Destination element index j |
| out_valid | output | 1 | Result valid |
| out_data | output | 64 | Element placed in its register lanes |
| out_mask | output | 8 | Byte-lane write enables |
| out_undef | output | 1 | Destination narrower than access |

## Verification
The hardest cases to reach are the clamp boundaries in saturating mode. Reaching them requires the access value to sit exactly at, or one step outside, the destination's signed or unsigned limits, after byte ordering has been applied. The vector table places values such as 0x7FFF, 0xFFFF8000, 0x80000000 and 0x0100 directly in the low bytes with byte reversal disabled. This keeps the boundary arithmetic visible. Separate rows use all four flag combinations of the reversal rule and index values beyond the lane count, so the swap gate and the index wrap are each exercised alone.

// File: rtl/ldf_pkg.sv
package ldf_pkg;

  typedef enum logic [1:0] {
    WID_8  = 2'd0,
    WID_16 = 2'd1,
    WID_32 = 2'd2,
    WID_64 = 2'd3
  } wid_e;

  // all-ones mask covering the given width code, for a 64-bit datapath
  function automatic logic [63:0] width_mask(input logic [1:0] w);
    case (w)
      2'd0:    width_mask = 64'h0000_0000_0000_00FF;
      2'd1:    width_mask = 64'h0000_0000_0000_FFFF;
      2'd2:    width_mask = 64'h0000_0000_FFFF_FFFF;
      default: width_mask = 64'hFFFF_FFFF_FFFF_FFFF;
    endcase
  endfunction

  // number of bytes for a width code
  function automatic logic [3:0] width_bytes(input logic [1:0] w);
    width_bytes = 4'd1 << w;
  endfunction

endpackage

// File: rtl/ldf_byte_order.sv
module ldf_byte_order #(
  parameter int REG_BYTES = 8,
  localparam int REG_W = REG_BYTES * 8,
  localparam int NUM_W = 4
) (
  input  logic [REG_W-1:0] din,
  input  logic [1:0]       wcode,
  input  logic             swap,
  output logic [REG_W-1:0] dout
);

  logic [REG_W-1:0] cand [NUM_W];

  // one candidate per access width: straight or reversed low bytes
  for (genvar gw = 0; gw < NUM_W; gw++) begin : g_wid
    localparam int NB = 1 << gw;
    logic [REG_W-1:0] fwd;
    logic [REG_W-1:0] rev;
    for (genvar gb = 0; gb < REG_BYTES; gb++) begin : g_byte
      if (gb < NB) begin : g_in
        assign fwd[gb*8 +: 8] = din[gb*8 +: 8];
        assign rev[gb*8 +: 8] = din[(NB-1-gb)*8 +: 8];
      end else begin : g_out
        assign fwd[gb*8 +: 8] = 8'h00;
        assign rev[gb*8 +: 8] = 8'h00;
      end
    end
    assign cand[gw] = swap ? rev : fwd;
  end

  assign dout = cand[wcode];

endmodule

// File: rtl/ldf_resize.sv
module ldf_resize
  import ldf_pkg::*;
#(
  parameter int REG_BYTES = 8,
  localparam int REG_W = REG_BYTES * 8
) (
  input  logic [REG_W-1:0] din,
  input  logic [1:0]       op_w,
  input  logic [1:0]       dst_w,
  input  logic             sat_en,
  input  logic             sat_signed,
  output logic [REG_W-1:0] elem,
  output logic             undef
);

  logic [REG_W-1:0] op_mask;
  logic [REG_W-1:0] d_mask;
  logic [REG_W-1:0] sext;
  logic [REG_W-1:0] s_max;
  logic [REG_W-1:0] s_min;
  logic [REG_W-1:0] val;
  logic             sign_bit;

  always_comb begin
    op_mask  = width_mask(op_w);
    d_mask   = width_mask(dst_w);
    sign_bit = din[(8 << op_w) - 1];
    sext     = sign_bit ? (din | ~op_mask) : din;
    s_max    = d_mask >> 1;
    s_min    = ~s_max;
    if (!sat_en) begin
      val = din;
    end else if (sat_signed) begin
      if ($signed(sext) > $signed(s_max))      val = s_max;
      else if ($signed(sext) < $signed(s_min)) val = s_min;
      else                                     val = sext;
    end else begin
      val = (din > d_mask) ? d_mask : din;
    end
    elem  = val & d_mask;
    undef = (dst_w < op_w);
  end

endmodule

// File: rtl/ldf_place.sv
module ldf_place
  import ldf_pkg::*;
#(
  parameter int REG_BYTES = 8,
  localparam int REG_W = REG_BYTES * 8,
  localparam int IDX_W = $clog2(REG_BYTES)
) (
  input  logic [REG_W-1:0]     elem,
  input  logic [1:0]           dst_w,
  input  logic [IDX_W-1:0]     idx,
  output logic [REG_W-1:0]     data,
  output logic [REG_BYTES-1:0] mask
);

  logic [IDX_W-1:0]     lane_mask;
  logic [IDX_W-1:0]     off;
  logic [REG_BYTES-1:0] base_mask;

  always_comb begin
    lane_mask = IDX_W'((REG_BYTES >> dst_w) - 1);
    off       = (idx & lane_mask) << dst_w;
    base_mask = REG_BYTES'((1 << width_bytes(dst_w)) - 1);
    data      = elem << {off, 3'b000};
    mask      = base_mask << off;
  end

endmodule

// File: rtl/ld_elem_formatter.sv
module ld_elem_formatter
  import ldf_pkg::*;
#(
  parameter int REG_BYTES = 8,
  localparam int REG_W = REG_BYTES * 8,
  localparam int IDX_W = $clog2(REG_BYTES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [REG_W-1:0]     raw_data,
  input  logic [1:0]           op_width,
  input  logic [1:0]           dst_width,
  input  logic                 brev_op,
  input  logic                 cpu_le,
  input  logic                 sat_en,
  input  logic                 sat_signed,
  input  logic [IDX_W-1:0]     elem_idx,
  output logic                 out_valid,
  output logic [REG_W-1:0]     out_data,
  output logic [REG_BYTES-1:0] out_mask,
  output logic                 out_undef
);

  logic [REG_W-1:0]     ordered;
  logic [REG_W-1:0]     elem;
  logic                 undef_c;
  logic [REG_W-1:0]     placed;
  logic [REG_BYTES-1:0] lanes;
  logic [1:0]           dst_q;
  logic [1:0]           op_q;

  // swap when the opcode flag matches the endian flag
  ldf_byte_order #(.REG_BYTES(REG_BYTES)) i_order (
    .din   (raw_data),
    .wcode (op_width),
    .swap  (~(brev_op ^ cpu_le)),
    .dout  (ordered)
  );

  ldf_resize #(.REG_BYTES(REG_BYTES)) i_resize (
    .din        (ordered),
    .op_w       (op_width),
    .dst_w      (dst_width),
    .sat_en     (sat_en),
    .sat_signed (sat_signed),
    .elem       (elem),
    .undef      (undef_c)
  );

  ldf_place #(.REG_BYTES(REG_BYTES)) i_place (
    .elem  (elem),
    .dst_w (dst_width),
    .idx   (elem_idx),
    .data  (placed),
    .mask  (lanes)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_mask  <= '0;
      out_undef <= 1'b0;
      dst_q     <= 2'd0;
      op_q      <= 2'd0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data  <= placed;
        out_mask  <= lanes;
        out_undef <= undef_c;
        dst_q     <= dst_width;
        op_q      <= op_width;
      end
    end
  end

  // bit-level expansion of the byte mask, for checking only
  logic [REG_W-1:0] mask_bits;
  for (genvar gb = 0; gb < REG_BYTES; gb++) begin : g_mbits
    assign mask_bits[gb*8 +: 8] = {8{out_mask[gb]}};
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!out_valid && out_mask == '0 && !out_undef)); // R1
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_data) && $stable(out_mask) && $stable(out_undef))); // R8
  AST_MASK_SIZE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($countones(out_mask) == int'(width_bytes(dst_q)))); // R6
  AST_DATA_IN_LANES: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((out_data & ~mask_bits) == '0)); // R6
  AST_UNDEF_WIDTHS: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_undef == (dst_q < op_q))); // R7

endmodule

// File: tb/test_ld_elem_formatter.sv
module test_ld_elem_formatter;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [63:0] raw;
    logic [1:0]  opw;
    logic [1:0]  dw;
    logic        brev;
    logic        le;
    logic        sat;
    logic        sgn;
    logic [2:0]  idx;
    logic [3:0]  req;
    logic [63:0] edata;
    logic [7:0]  emask;
    logic        eundef;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    // R2 no swap (le=1, brev=0)
    '{64'h1122334455667788, 2'd3, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 4'd2, 64'h1122334455667788, 8'hFF, 1'b0},
    // R2 swap (le=0, brev=0)
    '{64'h1122334455667788, 2'd3, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 4'd2, 64'h8877665544332211, 8'hFF, 1'b0},
    // R2 swap (le=1, brev=1)
    '{64'h1122334455667788, 2'd3, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 4'd2, 64'h8877665544332211, 8'hFF, 1'b0},
    // R2 no swap (le=0, brev=1)
    '{64'h1122334455667788, 2'd3, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 4'd2, 64'h1122334455667788, 8'hFF, 1'b0},
    // R3 16-bit swapped, zero-extended to 32 at lane 1
    '{64'h1122334455667788, 2'd1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 4'd3, 64'h0000887700000000, 8'hF0, 1'b0},
    // R4 signed widen 8 -> 16 at lane 3
    '{64'h1122334455667788, 2'd0, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 3'd3, 4'd4, 64'hFF88000000000000, 8'hC0, 1'b0},
    // R4 unsigned widen 8 -> 16 at lane 2
    '{64'h1122334455667788, 2'd0, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 3'd2, 4'd4, 64'h0000008800000000, 8'h30, 1'b0},
    // R7 undefined narrowing, plain truncation, lane 5
    '{64'h0000000012345678, 2'd2, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd5, 4'd7, 64'h0000780000000000, 8'h20, 1'b1},
    // R5 signed clamp high
    '{64'h0000000012345678, 2'd2, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 3'd0, 4'd5, 64'h0000000000007FFF, 8'h03, 1'b1},
    // R5 signed clamp low at lane 1
    '{64'h0000000080000000, 2'd2, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 3'd1, 4'd5, 64'h0000000080000000, 8'h0C, 1'b1},
    // R5 signed exact minimum passes
    '{64'h00000000FFFF8000, 2'd2, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 3'd0, 4'd5, 64'h0000000000008000, 8'h03, 1'b1},
    // R5 signed exact maximum passes
    '{64'h0000000000007FFF, 2'd2, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 3'd0, 4'd5, 64'h0000000000007FFF, 8'h03, 1'b1},
    // R5 unsigned clamp at lane 7
    '{64'h0000000000000100, 2'd1, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 3'd7, 4'd5, 64'hFF00000000000000, 8'h80, 1'b1},
    // R5 unsigned exact maximum passes
    '{64'h00000000000000FF, 2'd1, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 3'd0, 4'd5, 64'h00000000000000FF, 8'h01, 1'b1},
    // R6 index ignored for 64-bit destination, upper raw bytes dropped
    '{64'hDEADBEEFCAFEBABE, 2'd2, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 3'd5, 4'd6, 64'h00000000CAFEBABE, 8'hFF, 1'b0},
    // R4 signed widen 16 -> 64
    '{64'h0000000000008001, 2'd1, 2'd3, 1'b0, 1'b1, 1'b1, 1'b1, 3'd0, 4'd4, 64'hFFFFFFFFFFFF8001, 8'hFF, 1'b0},
    // R6 index wraps: 32-bit destination, idx 6 -> lane 0, swapped 32-bit
    '{64'h1122334455667788, 2'd2, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 3'd6, 4'd6, 64'h0000000088776655, 8'h0F, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] raw_data = '0;
  logic [1:0]  op_width = '0;
  logic [1:0]  dst_width = '0;
  logic        brev_op = 1'b0;
  logic        cpu_le = 1'b1;
  logic        sat_en = 1'b0;
  logic        sat_signed = 1'b0;
  logic [2:0]  elem_idx = '0;
  logic        out_valid;
  logic [63:0] out_data;
  logic [7:0]  out_mask;
  logic        out_undef;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ld_elem_formatter i_ld_elem_formatter (
    .clk(clk), .rst(rst), .in_valid(in_valid), .raw_data(raw_data),
    .op_width(op_width), .dst_width(dst_width), .brev_op(brev_op), .cpu_le(cpu_le),
    .sat_en(sat_en), .sat_signed(sat_signed), .elem_idx(elem_idx),
    .out_valid(out_valid), .out_data(out_data), .out_mask(out_mask), .out_undef(out_undef)
  );

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    raw_data = v.raw; op_width = v.opw; dst_width = v.dw; brev_op = v.brev;
    cpu_le = v.le; sat_en = v.sat; sat_signed = v.sgn; elem_idx = v.idx;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "out_valid", {63'd0, out_valid}, 64'd0);
    check("R1", "out_data", out_data, 64'd0);
    check("R1", "out_mask", {56'd0, out_mask}, 64'd0);
    check("R1", "out_undef", {63'd0, out_undef}, 64'd0);
    rst = 1'b0;

    for (int n = 0; n < NV; n++) begin
      drive(VECS[n]);
      in_valid = 1'b1;
      @(negedge clk);
      check($sformatf("R%0d", VECS[n].req), $sformatf("vec%0d data", n), out_data, VECS[n].edata);
      check($sformatf("R%0d", VECS[n].req), $sformatf("vec%0d mask", n), {56'd0, out_mask}, {56'd0, VECS[n].emask});
      check($sformatf("R%0d", VECS[n].req), $sformatf("vec%0d undef", n), {63'd0, out_undef}, {63'd0, VECS[n].eundef});
      check("R1", $sformatf("vec%0d valid", n), {63'd0, out_valid}, 64'd1);
    end

    // R8 idle cycle: change inputs, outputs must hold last result
    in_valid = 1'b0;
    drive(VECS[0]);
    @(negedge clk);
    check("R8", "valid low", {63'd0, out_valid}, 64'd0);
    check("R8", "data held", out_data, VECS[NV-1].edata);
    check("R8", "mask held", {56'd0, out_mask}, {56'd0, VECS[NV-1].emask});

    // R1 single-cycle valid pulse
    in_valid = 1'b1;
    drive(VECS[5]);
    @(negedge clk);
    in_valid = 1'b0;
    check("R1", "pulse high", {63'd0, out_valid}, 64'd1);
    @(negedge clk);
    check("R1", "pulse low", {63'd0, out_valid}, 64'd0);

    // R1 reset in mid-run clears outputs
    in_valid = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    check("R1", "rst valid", {63'd0, out_valid}, 64'd0);
    check("R1", "rst data", out_data, 64'd0);
    check("R1", "rst mask", {56'd0, out_mask}, 64'd0);
    rst = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule